// File: doc/BRIEF.md
# DDR Nibble Lane Codec

This block joins a byte-wide, single-data-rate transmit and receive interface to a 5-bit double-data-rate lane, for one channel. Each clock cycle on the lane carries two half-cycle words: one for the rising edge and one for the falling edge. In each word, bit 4 is a control bit and bits [3:0] are a data nibble. The DDR pins are modelled as a pair of half-cycle word ports. DDR cells, clock skew and delay tuning belong to the pad ring. Source-centred and source-aligned clocking differ only in the clock phase at the pads, so both use the same word order here.

The transmit half registers a byte with its enable and error flags. It then emits the half-cycle pair. The low-nibble word carries the enable. The high-nibble word carries enable XOR error. The receive half takes a captured pair and rebuilds the byte, a data-valid flag and an error flag. A nibble-order input chooses which edge carries the low nibble. Both lanes stream continuously at one byte per clock and have no back-pressure. The transmit enable and the received data-valid flag play the part of a valid qualifier, and no ready signal exists, so every cycle must be accepted.

Top module: `ddr_nibble_codec`

## Requirements
- R1: With `lo_first`=1, the transmit rising word is {tx_en, tx_data[3:0]} and the falling word is {tx_en^tx_er, tx_data[7:4]}. Bit 4 of each word is the control bit.
- R2: With `lo_first`=0, the transmitter swaps the two words. The rising word is {tx_en^tx_er, tx_data[7:4]} and the falling word is {tx_en, tx_data[3:0]}.
- R3: The transmit words reflect the inputs sampled at one rising clock edge and are present from just after that edge until the next one.
- R4: The receiver takes the low-nibble word from the rising word when `lo_first`=1 and from the falling word when `lo_first`=0. The high-nibble word is the other one. It outputs rx_data = {high[3:0], low[3:0]}, rx_dv = low[4] and rx_er = low[4]^high[4].
- R5: Receive outputs reflect the lane words sampled at one rising edge and are present from just after that edge until the next one.
- R6: With tx_en=0 and tx_er=1, the low-nibble word's control bit is 0 and the high-nibble word's control bit is 1. A received pair of that form gives rx_dv=0 and rx_er=1.
- R7: `lo_first` is sampled at the same edge as the data it orders. Toggling it every cycle orders each byte by its own sampled value, and no byte is split across two orderings.
- R8: A synchronous active-high `rst` drives every transmit word bit and every receive output to 0 at the next edge.
- R9: With tx_en=0 and tx_er=0, both transmit control bits are 0. A received pair with both control bits 0 gives rx_dv=0 and rx_er=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| lo_first | input | 1 | 1: low nibble on the rising half; 0: on the falling half |
| tx_en | input | 1 | Transmit enable for the byte |
| tx_er | input | 1 | Transmit error for the byte |
| tx_data | input | 8 | Transmit byte |
| lane_tx_rise | output | 5 | Rising-edge transmit word {ctrl, nibble} |
| lane_tx_fall | output | 5 | Falling-edge transmit word {ctrl, nibble} |
| lane_rx_rise | input | 5 | Captured rising-edge receive word |
| lane_rx_fall | input | 5 | Captured falling-edge receive word |
| rx_dv | output | 1 | Received data valid |
| rx_er | output | 1 | Received error |
| rx_data | output | 8 | Received byte |

## Verification
Both halves have one register of latency. Inputs driven at a falling clock edge are sampled by the next rising edge, and every output that depends on them is due one time step after that rising edge. The driver pushes the expected words and flags for each cycle into a queue at the falling edge where it drives the inputs. The monitor pops one entry one time step after each rising edge, so every comparison lands on the cycle its result is due. Reset, idle and error-only cycles, and a nibble order toggled every cycle, all pass through that same queue.

// File: rtl/ddr_nibble_pkg.sv
package ddr_nibble_pkg;
  parameter int unsigned NIB_W  = 4;
  localparam int unsigned WORD_W = NIB_W + 1;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  // place the low/high words on the two edges (or pick them back out)
  function automatic logic [2*WORD_W-1:0] order_pair(
      input logic lo_first_i,
      input logic [WORD_W-1:0] a_i,
      input logic [WORD_W-1:0] b_i);
    return lo_first_i ? {a_i, b_i} : {b_i, a_i};
  endfunction
endpackage

// File: rtl/nib_tx_pack.sv
module nib_tx_pack
  import ddr_nibble_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_first,
  input  logic              en,
  input  logic              er,
  input  logic [BYTE_W-1:0] data,
  output logic [WORD_W-1:0] rise,
  output logic [WORD_W-1:0] fall
);
  logic [WORD_W-1:0]   lo_w, hi_w;
  logic [2*WORD_W-1:0] placed;

  always_comb begin
    lo_w   = {en, data[NIB_W-1:0]};
    hi_w   = {en ^ er, data[BYTE_W-1:NIB_W]};
    placed = order_pair(lo_first, lo_w, hi_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise <= '0;
      fall <= '0;
    end else begin
      rise <= placed[2*WORD_W-1:WORD_W];
      fall <= placed[WORD_W-1:0];
    end
  end

  // R8
  tx_reset_zero_chk: assert property (@(posedge clk)
    rst |=> (rise == '0 && fall == '0));
  // R9
  tx_idle_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !er) |=> (!rise[WORD_W-1] && !fall[WORD_W-1]));
  // R6
  tx_err_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && er && lo_first) |=> (!rise[WORD_W-1] && fall[WORD_W-1]));
  // R6
  tx_err_only_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && er && !lo_first) |=> (rise[WORD_W-1] && !fall[WORD_W-1]));
endmodule

// File: rtl/nib_rx_unpack.sv
module nib_rx_unpack
  import ddr_nibble_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_first,
  input  logic [WORD_W-1:0] rise,
  input  logic [WORD_W-1:0] fall,
  output logic              dv,
  output logic              er,
  output logic [BYTE_W-1:0] data
);
  logic [2*WORD_W-1:0] picked;
  logic [WORD_W-1:0]   lo_w, hi_w;

  always_comb begin
    picked = order_pair(lo_first, rise, fall);
    lo_w   = picked[2*WORD_W-1:WORD_W];
    hi_w   = picked[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv   <= 1'b0;
      er   <= 1'b0;
      data <= '0;
    end else begin
      dv   <= lo_w[WORD_W-1];
      er   <= lo_w[WORD_W-1] ^ hi_w[WORD_W-1];
      data <= {hi_w[NIB_W-1:0], lo_w[NIB_W-1:0]};
    end
  end

  // R8
  rx_reset_zero_chk: assert property (@(posedge clk)
    rst |=> (!dv && !er && data == '0));
  // R9
  rx_idle_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise[WORD_W-1] && !fall[WORD_W-1]) |=> (!dv && !er));
  // R6
  rx_err_only_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_first && !rise[WORD_W-1] && fall[WORD_W-1]) |=> (!dv && er));
endmodule

// File: rtl/ddr_nibble_codec.sv
module ddr_nibble_codec
  import ddr_nibble_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_first,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [WORD_W-1:0] lane_tx_rise,
  output logic [WORD_W-1:0] lane_tx_fall,
  input  logic [WORD_W-1:0] lane_rx_rise,
  input  logic [WORD_W-1:0] lane_rx_fall,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [BYTE_W-1:0] rx_data
);
  nib_tx_pack u_tx (
    .clk(clk), .rst(rst), .lo_first(lo_first),
    .en(tx_en), .er(tx_er), .data(tx_data),
    .rise(lane_tx_rise), .fall(lane_tx_fall)
  );

  nib_rx_unpack u_rx (
    .clk(clk), .rst(rst), .lo_first(lo_first),
    .rise(lane_rx_rise), .fall(lane_rx_fall),
    .dv(rx_dv), .er(rx_er), .data(rx_data)
  );
endmodule

// File: tb/ddr_nibble_codec_bench.sv
module ddr_nibble_codec_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo_first = 1'b1;
  logic tx_en = 1'b0, tx_er = 1'b0;
  logic [7:0] tx_data = '0;
  logic [4:0] lane_rx_rise = '0, lane_rx_fall = '0;
  logic [4:0] lane_tx_rise, lane_tx_fall;
  logic rx_dv, rx_er;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected: {tx_rise, tx_fall, rx_dv, rx_er, rx_data}
  logic [19:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_nibble_codec u_ddr_nibble_codec (
    .clk(clk), .rst(rst), .lo_first(lo_first),
    .tx_en(tx_en), .tx_er(tx_er), .tx_data(tx_data),
    .lane_tx_rise(lane_tx_rise), .lane_tx_fall(lane_tx_fall),
    .lane_rx_rise(lane_rx_rise), .lane_rx_fall(lane_rx_fall),
    .rx_dv(rx_dv), .rx_er(rx_er), .rx_data(rx_data)
  );

  task automatic step(input logic r, input logic ord, input logic en,
                      input logic er, input logic [7:0] d,
                      input logic [4:0] rr, input logic [4:0] rf,
                      input string tag);
    logic [4:0] lo, hi, er_, ef_, xlo, xhi;
    logic [19:0] e;
    @(negedge clk);
    rst = r; lo_first = ord; tx_en = en; tx_er = er; tx_data = d;
    lane_rx_rise = rr; lane_rx_fall = rf;
    lo = {en, d[3:0]};
    hi = {en ^ er, d[7:4]};
    er_ = ord ? lo : hi;
    ef_ = ord ? hi : lo;
    xlo = ord ? rr : rf;
    xhi = ord ? rf : rr;
    if (r) e = '0;
    else e = {er_, ef_, xlo[4], xlo[4] ^ xhi[4], xhi[3:0], xlo[3:0]};
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // monitor: result of inputs driven at the prior falling edge
  always begin
    @(posedge clk);
    #1;
    if (expq.size() > 0) begin
      logic [19:0] e, a;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      a = {lane_tx_rise, lane_tx_fall, rx_dv, rx_er, rx_data};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8 reset state with busy inputs
    step(1, 1, 1, 1, 8'hA5, 5'h1F, 5'h1F, "R8 reset");
    step(1, 0, 1, 0, 8'h3C, 5'h15, 5'h0A, "R8 reset");
    // R1 R3 R4 R5 default order
    step(0, 1, 1, 0, 8'h5A, 5'h13, 5'h1C, "R1 R4 order1");
    step(0, 1, 1, 0, 8'hF0, 5'h10, 5'h1F, "R3 R5 order1");
    step(0, 1, 1, 1, 8'h81, 5'h17, 5'h02, "R1 R4 en+er");
    // R2 R4 swapped order
    step(0, 0, 1, 0, 8'h5A, 5'h1C, 5'h13, "R2 R4 order0");
    step(0, 0, 1, 1, 8'h7E, 5'h0E, 5'h17, "R2 R4 en+er");
    // R9 idle
    step(0, 1, 0, 0, 8'h00, 5'h00, 5'h00, "R9 idle");
    step(0, 0, 0, 0, 8'hC3, 5'h06, 5'h09, "R9 idle data");
    // R6 error without enable
    step(0, 1, 0, 1, 8'h00, 5'h00, 5'h10, "R6 er-only order1");
    step(0, 0, 0, 1, 8'h96, 5'h19, 5'h06, "R6 er-only order0");
    // R7 order toggled every cycle
    for (int i = 0; i < 12; i++)
      step(0, i[0], 1, i[2], 8'(i * 37 + 5), 5'(i * 11), 5'(i * 7 + 3),
           "R7 toggle");
    // random mix
    for (int i = 0; i < 30; i++)
      step(0, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
           5'($urandom), 5'($urandom), "R1 R2 R4 random");
    // R8 reset mid-stream then recovery
    step(1, 1, 1, 0, 8'hEE, 5'h1E, 5'h1E, "R8 mid reset");
    step(0, 1, 1, 0, 8'h42, 5'h12, 5'h14, "R3 R5 after reset");
    step(0, 1, 0, 0, 8'h00, 5'h00, 5'h00, "R9 drain");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule